// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Flush on Disable

This block receives asynchronous serial frames of five to nine data bits, least significant bit first, with an optional parity bit and one stop bit. The receive line is oversampled with a tick input that runs at sixteen times the bit rate. Each finished character is stored in a small receive buffer together with its ninth bit and its frame, parity and overrun status. A bus-side master reads the head of the buffer. It reads the ninth bit and the flags first, then reads the low byte. Reading the low byte removes the character from the buffer.

The receiver enable is a level input. While it is high, the receiver owns the line input and reports that ownership on a separate output. When the enable goes low, the buffer is cleared at once and all status flags read zero. Any character that was waiting is lost.

Top module: `sr_rx_flush`

## Requirements
- R1: One cycle after `rx_en` is sampled low, `rx_done`, `ferr`, `dovr`, `perr`, `rd_bit9` and `rd_data` read 0. Characters that were buffered before are lost and do not come back when the receiver is enabled again.
- R2: `rx_own` follows `rx_en`. While the receiver is disabled, line activity produces no character.
- R3: The size code `char_sz` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8 and 7 gives 9. Codes 4, 5 and 6 give 8. Bits arrive least significant first. Data bits above the selected size read 0, and `rd_bit9` reads 0 for sizes below 9.
- R4: In 9-bit mode, `rd_bit9` carries bit 8 of the character at the head of the buffer. It stays with that character until the low byte is read.
- R5: A one-cycle `rd_lo` pulse pops the head. The buffer holds `DEPTH` characters (2 by default) and returns them in arrival order.
- R6: A falling edge starts a frame only if the line is still low at the eighth tick sample. Otherwise the receiver returns to idle and produces no character.
- R7: Each data, parity and stop bit is decided by a majority of its samples 7, 8 and 9. A glitch that covers only one of these samples does not change the bit.
- R8: `ferr` is 1 for a character whose stop bit was sampled low.
- R9: `par_mode` 2 selects even parity and 3 selects odd parity. With either, `perr` is 1 when the received parity bit does not match the data. With `par_mode` 0 or 1 no parity bit is expected and `perr` is 0.
- R10: A character that completes while the buffer is full is discarded. `dovr` then reads 1 while the most recently stored character is at the head.
- R11: `rx_done` is 1 exactly when the buffer holds unread characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable; low flushes the buffer |
| char_sz | input | 3 | Character size code |
| par_mode | input | 2 | Parity: 0/1 none, 2 even, 3 odd |
| rd_lo | input | 1 | Pulse: low byte read, pops the head |
| tick16 | input | 1 | Oversampling tick at 16x bit rate |
| rx_pin | input | 1 | Serial receive line |
| rx_own | output | 1 | Receiver owns the line input |
| rd_data | output | 8 | Low byte of the head character |
| rd_bit9 | output | 1 | Ninth data bit of the head character |
| rx_done | output | 1 | Buffer holds unread data |
| ferr | output | 1 | Frame error of the head character |
| dovr | output | 1 | Overrun marker of the head character |
| perr | output | 1 | Parity error of the head character |

## Verification
Some properties are checked on every cycle. The flush leaves every status output at zero one cycle after the enable is low. A rise of `rx_done` always follows a completed frame. The buffer count never exceeds its depth, and a full buffer stays full when an extra character arrives. A failed start check always returns the sampler to idle. Other behaviour shows only in the bench scenarios: character values assembled at every size code, parity verdicts, the majority vote masking a glitch, the arrival order and overrun marking seen through reads, and the loss of data on disable.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP
  } rx_state_t;

  typedef struct packed {
    logic       dor;
    logic       pe;
    logic       fe;
    logic [8:0] data;
  } rx_ent_t;

  // two of three samples decide the bit
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // size code to number of data bits
  function automatic logic [3:0] size_of_code(input logic [2:0] code);
    case (code)
      3'd0: return 4'd5;
      3'd1: return 4'd6;
      3'd2: return 4'd7;
      3'd7: return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

  // bits shift in from the top; right-justify after n shifts
  function automatic logic [8:0] align_data(input logic [8:0] sh, input logic [3:0] n);
    return sh >> (4'd9 - n);
  endfunction

endpackage

// File: rtl/rx_sampler.sv
module rx_sampler
  import rxf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       rxd,
  input  logic [3:0] nbits,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       frame_done,
  output logic [8:0] frame_data,
  output logic       frame_fe,
  output logic       frame_pe
);

  rx_state_t  st;
  logic [3:0] cnt;
  logic [3:0] bidx;
  logic [8:0] sh;
  logic       s0, s1, pbit;
  logic       vote;
  logic [8:0] aligned;

  assign vote    = maj3(s0, s1, rxd);
  assign aligned = align_data(sh, nbits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      bidx       <= '0;
      sh         <= '0;
      s0         <= 1'b1;
      s1         <= 1'b1;
      pbit       <= 1'b0;
      frame_done <= 1'b0;
      frame_data <= '0;
      frame_fe   <= 1'b0;
      frame_pe   <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (!en) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else if (tick) begin
        if (st == S_IDLE) begin
          if (!rxd) begin
            st  <= S_START;
            cnt <= 4'd1;
          end
        end else begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd6) s0 <= rxd;
          if (cnt == 4'd7) s1 <= rxd;
          case (st)
            S_START: begin
              if (cnt == 4'd7 && rxd) st <= S_IDLE;
              else if (cnt == 4'd15) begin
                st   <= S_DATA;
                bidx <= '0;
              end
            end
            S_DATA: begin
              if (cnt == 4'd8) sh <= {vote, sh[8:1]};
              if (cnt == 4'd15) begin
                if (bidx == 4'(nbits - 4'd1)) st <= par_en ? S_PAR : S_STOP;
                else bidx <= bidx + 4'd1;
              end
            end
            S_PAR: begin
              if (cnt == 4'd8) pbit <= vote;
              else if (cnt == 4'd15) st <= S_STOP;
            end
            S_STOP: begin
              if (cnt == 4'd8) begin
                frame_done <= 1'b1;
                frame_data <= aligned;
                frame_fe   <= ~vote;
                frame_pe   <= par_en & ((^aligned) ^ pbit ^ par_odd);
                st         <= S_IDLE;
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  // R6: failed start sample returns to idle
  p_false_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && st == S_START && cnt == 4'd7 && rxd) |=> (st == S_IDLE));

  // R11: completion is a single-cycle event
  p_single_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

endmodule

// File: rtl/rx_buf.sv
module rx_buf
  import rxf_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    flush,
  input  logic    push,
  input  rx_ent_t push_ent,
  input  logic    pop,
  output rx_ent_t head,
  output logic    nonempty,
  output logic    full
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rx_ent_t         mem [DEPTH];
  logic [PW-1:0]   rptr, wptr;
  logic [CW-1:0]   count;
  logic            do_pop, do_push, overrun;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  function automatic logic [PW-1:0] prv(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - PW'(1);
  endfunction

  assign nonempty = (count != '0);
  assign full     = (count == CW'(DEPTH));
  assign do_pop   = pop & nonempty;
  assign do_push  = push & (!full | do_pop);
  assign overrun  = push & full & !do_pop;
  assign head     = nonempty ? mem[rptr] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wptr] <= push_ent;
        wptr      <= nxt(wptr);
      end
      if (overrun) mem[prv(wptr)].dor <= 1'b1;
      if (do_pop) rptr <= nxt(rptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R10: the count never passes the depth
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R10: an extra character leaves a full buffer full
  p_drop_keeps_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !flush) |=> full);

endmodule

// File: rtl/sr_rx_flush.sv
module sr_rx_flush
  import rxf_pkg::*;
#(
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic [2:0] char_sz,
  input  logic [1:0] par_mode,
  input  logic       rd_lo,
  input  logic       tick16,
  input  logic       rx_pin,
  output logic       rx_own,
  output logic [7:0] rd_data,
  output logic       rd_bit9,
  output logic       rx_done,
  output logic       ferr,
  output logic       dovr,
  output logic       perr
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rxd_s;
  logic                   frm_done, frm_fe, frm_pe;
  logic [8:0]             frm_data;
  rx_ent_t                new_ent, head;
  logic                   buf_full;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) sync_q <= !rst_n ? 1'b1 : rx_pin;
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_pin};
      end
    end
  endgenerate

  // line is seen as idle-high unless the receiver owns it
  assign rxd_s  = rx_en ? sync_q[SYNC_STAGES-1] : 1'b1;
  assign rx_own = rx_en;

  rx_sampler u_samp (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (rx_en),
    .tick      (tick16),
    .rxd       (rxd_s),
    .nbits     (size_of_code(char_sz)),
    .par_en    (par_mode[1]),
    .par_odd   (par_mode[0]),
    .frame_done(frm_done),
    .frame_data(frm_data),
    .frame_fe  (frm_fe),
    .frame_pe  (frm_pe)
  );

  assign new_ent = '{dor: 1'b0, pe: frm_pe, fe: frm_fe, data: frm_data};

  rx_buf #(.DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (!rx_en),
    .push    (frm_done),
    .push_ent(new_ent),
    .pop     (rd_lo),
    .head    (head),
    .nonempty(rx_done),
    .full    (buf_full)
  );

  assign rd_data = head.data[7:0];
  assign rd_bit9 = head.data[8];
  assign ferr    = head.fe;
  assign dovr    = head.dor;
  assign perr    = head.pe;

  // R1: disable empties the buffer and clears every flag
  p_flush_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_done && !ferr && !dovr && !perr && !rd_bit9 && rd_data == 8'h00));

  // R11: new unread data only appears after a completed frame
  p_done_after_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $past(frm_done));

  // R4: head character is stable while no read and no new completion
  p_head_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_en && !rd_lo) |=> (!rx_en || $stable({rd_bit9, rd_data, ferr, perr})));

endmodule

// File: tb/test_sr_rx_flush.sv
`timescale 1ns/1ps
module test_sr_rx_flush;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic [2:0] char_sz = 3'd3;
  logic [1:0] par_mode = 2'd0;
  logic       rd_lo = 1'b0;
  logic       tick16 = 1'b0;
  logic       rx_pin = 1'b1;
  logic       rx_own;
  logic [7:0] rd_data;
  logic       rd_bit9, rx_done, ferr, dovr, perr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  // one tick every second clock: 32 clocks per bit
  initial forever begin
    @(negedge clk);
    tick16 = ~tick16;
  end

  sr_rx_flush i_sr_rx_flush (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .char_sz(char_sz),
    .par_mode(par_mode), .rd_lo(rd_lo), .tick16(tick16), .rx_pin(rx_pin),
    .rx_own(rx_own), .rd_data(rd_data), .rd_bit9(rd_bit9), .rx_done(rx_done),
    .ferr(ferr), .dovr(dovr), .perr(perr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int nbits_of(input int code);
    if (code == 7) return 9;
    if (code >= 4) return 8;
    return code + 5;
  endfunction

  function automatic int ones(input int v, input int n);
    int c = 0;
    for (int i = 0; i < n; i++) c += (v >> i) & 1;
    return c;
  endfunction

  task automatic hold_bit(input logic b, input int glitch);
    for (int c = 0; c < 32; c++) begin
      rx_pin = (glitch != 0 && (c == 16 || c == 17)) ? ~b : b;
      @(negedge clk);
    end
  endtask

  // send one frame; glitch_bit >= 0 flips two clocks in that data bit
  task automatic send(input int val, input int n, input int pm,
                      input logic stop_ok, input logic par_flip, input int glitch_bit);
    logic p;
    hold_bit(1'b0, 0);
    for (int i = 0; i < n; i++) hold_bit(1'((val >> i) & 1), int'(i == glitch_bit));
    if (pm >= 2) begin
      p = 1'(ones(val, n) & 1) ^ 1'(pm & 1) ^ par_flip;
      hold_bit(p, 0);
    end
    if (stop_ok) hold_bit(1'b1, 0);
    else begin
      rx_pin = 1'b0;
      repeat (20) @(negedge clk);
      rx_pin = 1'b1;
      repeat (12) @(negedge clk);
    end
    rx_pin = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic pop();
    rd_lo = 1'b1;
    @(negedge clk);
    rd_lo = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int vals[4];
    int mask;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset rx_done", rx_done, 0);
    chk("R1 reset data", rd_data, 0);
    chk("R2 reset own", rx_own, 0);

    // R2: frame on a disabled receiver is ignored
    send(8'h5A, 8, 0, 1'b1, 1'b0, -1);
    chk("R2 disabled no data", rx_done, 0);
    rx_en = 1'b1;
    @(negedge clk);
    chk("R2 own follows enable", rx_own, 1);
    repeat (40) @(negedge clk);

    // R3 R9 R11 sweep of size codes and parity modes
    for (int code = 0; code < 8; code++) begin
      if (code == 5 || code == 6) continue;
      for (int pm = 0; pm < 4; pm++) begin
        if (pm == 1) continue;
        mask = (1 << nbits_of(code)) - 1;
        vals[0] = 0; vals[1] = mask; vals[2] = 'h155 & mask; vals[3] = ('h0B3 + code * 37) & mask;
        for (int k = 0; k < 4; k++) begin
          char_sz = 3'(code);
          par_mode = 2'(pm);
          send(vals[k] | (~mask & 'h1FF), nbits_of(code), pm, 1'b1, 1'(k == 3 && pm != 0), -1);
          chk("R11 done after frame", rx_done, 1);
          chk("R3 low byte", rd_data, vals[k] & 'hFF);
          chk("R3 R4 ninth bit", rd_bit9, (vals[k] >> 8) & 1);
          chk("R9 parity flag", perr, int'(k == 3 && pm != 0));
          chk("R8 no frame error", ferr, 0);
          pop();
          chk("R11 empty after read", rx_done, 0);
        end
      end
    end

    // R7: single-sample glitch inside a data bit is outvoted
    char_sz = 3'd3; par_mode = 2'd0;
    send(8'hC6, 8, 0, 1'b1, 1'b0, 2);
    chk("R7 glitch masked", rd_data, 8'hC6);
    pop();

    // R8: stop bit low
    send(8'h3C, 8, 0, 1'b0, 1'b0, -1);
    chk("R8 frame error", ferr, 1);
    chk("R8 data kept", rd_data, 8'h3C);
    pop();
    repeat (200) @(negedge clk);
    chk("R6 no spurious frame after error", rx_done, 0);

    // R6: short low pulse is not a start
    rx_pin = 1'b0;
    repeat (8) @(negedge clk);
    rx_pin = 1'b1;
    repeat (500) @(negedge clk);
    chk("R6 false start rejected", rx_done, 0);

    // R4 R5: 9-bit ordering and ninth bit tied to head
    char_sz = 3'd7;
    send('h1AA, 9, 0, 1'b1, 1'b0, -1);
    send('h055, 9, 0, 1'b1, 1'b0, -1);
    chk("R4 ninth bit first", rd_bit9, 1);
    repeat (50) @(negedge clk);
    chk("R4 ninth bit held", rd_bit9, 1);
    chk("R5 first in order", rd_data, 'hAA);
    pop();
    chk("R4 ninth bit advances", rd_bit9, 0);
    chk("R5 second in order", rd_data, 'h55);
    pop();

    // R10: overrun
    char_sz = 3'd3;
    send('h11, 8, 0, 1'b1, 1'b0, -1);
    send('h22, 8, 0, 1'b1, 1'b0, -1);
    send('h33, 8, 0, 1'b1, 1'b0, -1);
    chk("R10 head no overrun", dovr, 0);
    chk("R10 head data", rd_data, 'h11);
    pop();
    chk("R10 overrun marked", dovr, 1);
    chk("R10 third dropped keep second", rd_data, 'h22);
    pop();
    chk("R10 third discarded", rx_done, 0);
    chk("R10 flag gone when empty", dovr, 0);

    // R1: flush on disable
    send('h81, 8, 3, 1'b1, 1'b1, -1);
    send('h7E, 8, 3, 1'b0, 1'b0, -1);
    chk("R1 data before disable", rx_done, 1);
    rx_en = 1'b0;
    @(negedge clk);
    chk("R1 rx_done cleared", rx_done, 0);
    chk("R1 perr cleared", perr, 0);
    chk("R1 data cleared", rd_data, 0);
    chk("R2 own released", rx_own, 0);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 lost after re-enable", rx_done, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule